// File: doc/BRIEF.md
# Masked Logical and Compare Pixel Writer

This block sits on the write path between a host and a word-wide pixel memory. Each host write carries one data word. Before that word is committed, the block applies three things in turn. First, an optional logical operation combines the host word with the word held in a read latch. Second, an optional byte-by-byte comparison of the host word against a compare register can veto individual bytes. Third, a per-bit write mask keeps selected bits of the stored word unchanged.

The read latch is filled by a dummy read. A host read pulse fetches the word at the given address. The latched word is then returned on the read port and stays available as the second operand for later logical writes. Address generation is done outside this block: the host supplies the address with every read and write.

Each write takes two cycles. In the first, the block fetches the stored word. In the second, it merges the result and commits it to memory. A one-cycle done pulse is raised when the commit happens, so an external address counter can advance. A high-speed burst flag turns off the logical and compare operations, so every write becomes a plain masked write.

Top module: `pixel_write_path`

## Requirements
- R1: A mask bit of 1 keeps the stored memory bit; a mask bit of 0 lets the processed host bit through, subject to R4.
- R2: Mode 3'b000 writes the host word itself (plain masked write).
- R3: Modes 3'b001, 3'b010 and 3'b011 write the host word OR, AND and XOR the read latch, respectively. The latch value used is the one present when the write is committed, not the stored word at the write address.
- R4: Mode 3'b110 writes each byte (bits 15:8 and 7:0 judged separately) only if the host byte equals the matching compare-register byte. Mode 3'b111 writes a byte only if they differ. A byte that fails keeps its stored value.
- R5: The mask of R1 also applies in the logical modes and the compare modes.
- R6: While the burst flag is 1, every mode acts as mode 3'b000. The reserved modes 3'b100 and 3'b101 also act as mode 3'b000.
- R7: A host read (host_rd=1, host_wr=0) loads the stored word at host_addr into the latch. read_valid and read_data show it two rising edges after the read is sampled. The latch holds until the next accepted read. host_rd is ignored while host_wr is 1.
- R8: write_done is a single-cycle pulse two rising edges after host_wr is sampled. Any read or write sampled at or after that second edge sees the committed word, including back-to-back accesses to the same address.
- R9: Reset clears read_valid, write_done and the read latch (read_data = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Word address for a read or a write |
| host_rd | input | 1 | Dummy-read request (loads the latch) |
| host_wr | input | 1 | Write request |
| host_wdata | input | 16 | Host write word |
| op_mode | input | 3 | Operation select, sampled with host_wr |
| bit_mask | input | 16 | Per-bit keep mask, sampled with host_wr |
| cmp_word | input | 16 | Compare register value, sampled with host_wr |
| burst_en | input | 1 | Burst-write flag, sampled with host_wr |
| read_data | output | 16 | Read latch contents |
| read_valid | output | 1 | Pulse when the latch has just been loaded |
| write_done | output | 1 | Pulse when a write has been committed |

## Verification
A write sampled on one rising edge has its result due on the second edge after it. At that edge write_done pulses and the memory holds the new word. A read follows the same two-edge rule for read_valid and read_data. The bench drives on falling edges and samples on the falling edge just after the due edge. It also checks the falling edge before the due edge, to see that the pulse is not early. Stored words are always fetched back through the read port. Back-to-back same-address accesses are issued on consecutive edges, so the commit and the fetch land on the same edge.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    MODE_COPY    = 3'b000,
    MODE_OR      = 3'b001,
    MODE_AND     = 3'b010,
    MODE_XOR     = 3'b011,
    MODE_RSV4    = 3'b100,
    MODE_RSV5    = 3'b101,
    MODE_KEEP_EQ = 3'b110,
    MODE_KEEP_NE = 3'b111
  } pw_mode_e;

  function automatic logic is_cmp_mode(input pw_mode_e m);
    return (m == MODE_KEEP_EQ) || (m == MODE_KEEP_NE);
  endfunction

endpackage

// File: rtl/pw_op_unit.sv
module pw_op_unit
  import pw_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8,
  localparam int NB = DW / BW
) (
  input  logic [2:0]    mode,
  input  logic          burst,
  input  logic [DW-1:0] host_word,
  input  logic [DW-1:0] latch_word,
  input  logic [DW-1:0] cmp_word,
  output logic [DW-1:0] op_word,
  output logic [NB-1:0] byte_en
);

  pw_mode_e eff_mode;
  logic [NB-1:0] byte_eq;

  // burst writes and reserved codes fall back to plain copy
  always_comb begin
    eff_mode = pw_mode_e'(mode);
    if (burst) eff_mode = MODE_COPY;
  end

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_cmp
      assign byte_eq[gb] = (host_word[gb*BW +: BW] == cmp_word[gb*BW +: BW]);
    end
  endgenerate

  always_comb begin
    unique case (eff_mode)
      MODE_OR:  op_word = host_word | latch_word;
      MODE_AND: op_word = host_word & latch_word;
      MODE_XOR: op_word = host_word ^ latch_word;
      default:  op_word = host_word;
    endcase
  end

  always_comb begin
    if (is_cmp_mode(eff_mode)) begin
      byte_en = (eff_mode == MODE_KEEP_EQ) ? byte_eq : ~byte_eq;
    end else begin
      byte_en = '1;
    end
  end

endmodule

// File: rtl/pw_merge.sv
module pw_merge #(
  parameter int DW = 16,
  parameter int BW = 8,
  localparam int NB = DW / BW
) (
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] op_word,
  input  logic [DW-1:0] keep_mask,
  input  logic [NB-1:0] byte_en,
  output logic [DW-1:0] new_word
);

  logic [DW-1:0] take;

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_byte
      assign take[gb*BW +: BW] = ~keep_mask[gb*BW +: BW] & {BW{byte_en[gb]}};
    end
  endgenerate

  assign new_word = (op_word & take) | (old_word & ~take);

endmodule

// File: rtl/pw_mem.sv
module pw_mem #(
  parameter int DW = 16,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);

  logic [DW-1:0] store [DEPTH];

  // read-first registered port pair, block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata_q <= store[raddr];
  end

endmodule

// File: rtl/pixel_write_path.sv
module pixel_write_path #(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int AW = 8,
  localparam int NB = DW / BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic [2:0]    op_mode,
  input  logic [DW-1:0] bit_mask,
  input  logic [DW-1:0] cmp_word,
  input  logic          burst_en,
  output logic [DW-1:0] read_data,
  output logic          read_valid,
  output logic          write_done
);

  // stage 1: request captured, stored word being fetched
  logic          s1_valid;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] s1_wdata;
  logic [2:0]    s1_mode;
  logic [DW-1:0] s1_mask;
  logic [DW-1:0] s1_cmp;
  logic          s1_burst;
  logic          rd_pend;

  logic [DW-1:0] mem_q;
  logic          fwd_hit_q;
  logic [DW-1:0] fwd_word_q;
  logic [DW-1:0] old_eff;
  logic [DW-1:0] op_word;
  logic [NB-1:0] byte_en;
  logic [DW-1:0] new_word;
  logic [DW-1:0] rd_latch;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      rd_pend  <= 1'b0;
    end else begin
      s1_valid <= host_wr;
      rd_pend  <= host_rd & ~host_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr) begin
      s1_addr  <= host_addr;
      s1_wdata <= host_wdata;
      s1_mode  <= op_mode;
      s1_mask  <= bit_mask;
      s1_cmp   <= cmp_word;
      s1_burst <= burst_en;
    end
  end

  pw_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk    (clk),
    .we     (s1_valid),
    .waddr  (s1_addr),
    .wdata  (new_word),
    .raddr  (host_addr),
    .rdata_q(mem_q)
  );

  // a commit on the same edge as a fetch of that address is forwarded
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit_q <= 1'b0;
    end else begin
      fwd_hit_q <= s1_valid && (s1_addr == host_addr);
    end
    fwd_word_q <= new_word;
  end

  assign old_eff = fwd_hit_q ? fwd_word_q : mem_q;

  pw_op_unit #(.DW(DW), .BW(BW)) op_i (
    .mode      (s1_mode),
    .burst     (s1_burst),
    .host_word (s1_wdata),
    .latch_word(rd_latch),
    .cmp_word  (s1_cmp),
    .op_word   (op_word),
    .byte_en   (byte_en)
  );

  pw_merge #(.DW(DW), .BW(BW)) merge_i (
    .old_word (old_eff),
    .op_word  (op_word),
    .keep_mask(s1_mask),
    .byte_en  (byte_en),
    .new_word (new_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_latch   <= '0;
      read_valid <= 1'b0;
      write_done <= 1'b0;
    end else begin
      read_valid <= rd_pend;
      write_done <= s1_valid;
      if (rd_pend) rd_latch <= old_eff;
    end
  end

  assign read_data = rd_latch;

  // R8: a sampled write produces the done pulse on the second edge
  p_done_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> ##1 write_done);

  // R7: an accepted read produces the valid pulse on the second edge
  p_valid_after_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> ##1 read_valid);

  // R7: latch only moves together with read_valid
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !read_valid |-> $stable(read_data));

  // R1: masked bits leave the stored word untouched
  p_mask_keeps_r1: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (((new_word ^ old_eff) & s1_mask) == '0));

  // R6: burst collapses the operator to a plain copy of every byte
  p_burst_plain_r6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_burst) |-> ((op_word == s1_wdata) && (&byte_en)));

endmodule

// File: tb/pixel_write_path_tb_top.sv
module pixel_write_path_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  host_addr;
  logic        host_rd, host_wr;
  logic [15:0] host_wdata;
  logic [2:0]  op_mode;
  logic [15:0] bit_mask, cmp_word;
  logic        burst_en;
  logic [15:0] read_data;
  logic        read_valid, write_done;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pixel_write_path dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .op_mode(op_mode),
    .bit_mask(bit_mask), .cmp_word(cmp_word), .burst_en(burst_en),
    .read_data(read_data), .read_valid(read_valid), .write_done(write_done)
  );

  // {burst, mode}, mask, cmp, old word, host word, expected
  localparam logic [83:0] VEC [0:10] = '{
    {4'h0, 16'h0000, 16'h0000, 16'h1234, 16'hABCD, 16'hABCD}, // R2
    {4'h0, 16'hFF00, 16'h0000, 16'h1234, 16'hABCD, 16'h12CD}, // R1
    {4'h1, 16'h0000, 16'h0000, 16'h00F0, 16'h0F00, 16'h0FF0}, // R3 or
    {4'h2, 16'h0000, 16'h0000, 16'h0FF0, 16'h00FF, 16'h00F0}, // R3 and
    {4'h3, 16'h000F, 16'h0000, 16'h5555, 16'hFFFF, 16'hAAA5}, // R3 xor, R5
    {4'h6, 16'h0000, 16'h12AB, 16'h0000, 16'h12CD, 16'h1200}, // R4 eq
    {4'h7, 16'h0000, 16'h12AB, 16'h7777, 16'h12CD, 16'h77CD}, // R4 ne
    {4'hB, 16'h0000, 16'h0000, 16'h5555, 16'h00FF, 16'h00FF}, // R6 burst xor
    {4'hE, 16'h0000, 16'h0000, 16'hFFFF, 16'h1234, 16'h1234}, // R6 burst cmp
    {4'h5, 16'h0000, 16'h0000, 16'h1111, 16'h2222, 16'h2222}, // R6 reserved
    {4'h6, 16'h00F0, 16'h00AB, 16'h1234, 16'h00AB, 16'h003B}  // R5 mask+cmp
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [3:0] bm,
                    input logic [15:0] m, input logic [15:0] c, input string req);
    @(negedge clk);
    host_addr = a; host_wdata = d; burst_en = bm[3]; op_mode = bm[2:0];
    bit_mask = m; cmp_word = c; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check(req, {15'd0, write_done}, 16'd0);
    @(negedge clk);
    check(req, {15'd0, write_done}, 16'd1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] q);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    check("R7 valid", {15'd0, read_valid}, 16'd1);
    q = read_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    rst = 1'b1; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    op_mode = 0; bit_mask = 0; cmp_word = 0; burst_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 read_data", read_data, 16'h0000);
    check("R9 read_valid", {15'd0, read_valid}, 16'd0);
    check("R9 write_done", {15'd0, write_done}, 16'd0);
    rst = 1'b0;

    for (int i = 0; i < 11; i++) begin
      logic [83:0] v;
      v = VEC[i];
      wr(8'(i + 1), v[47:32], 4'h0, 16'h0, 16'h0, "R8 setup");
      rd(8'(i + 1), q);
      check("R7 dummy read", q, v[47:32]);
      wr(8'(i + 1), v[31:16], v[83:80], v[79:64], v[63:48], "R8 done");
      rd(8'(i + 1), q);
      check($sformatf("R1-R6 vector %0d", i), q, v[15:0]);
    end

    // R3: logical op uses the latch, not the word at the write address
    wr(8'h40, 16'h00F0, 4'h0, 16'h0, 16'h0, "R8 setup");
    wr(8'h41, 16'h0F00, 4'h0, 16'h0, 16'h0, "R8 setup");
    rd(8'h41, q);
    wr(8'h40, 16'h0000, 4'h1, 16'h0, 16'h0, "R8 done");
    rd(8'h40, q);
    check("R3 latch operand", q, 16'h0F00);

    // R7: read ignored while a write is sampled; latch keeps 16'h0F00
    @(negedge clk);
    host_addr = 8'h41; host_wdata = 16'h5A5A; op_mode = 0; burst_en = 0;
    bit_mask = 0; host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    @(negedge clk);
    check("R7 rd ignored valid", {15'd0, read_valid}, 16'd0);
    check("R7 rd ignored latch", read_data, 16'h0F00);

    // R8: back-to-back writes to one address, then immediate read
    @(negedge clk);
    host_addr = 8'h50; host_wdata = 16'hFFFF; bit_mask = 16'h0000; host_wr = 1'b1;
    @(negedge clk);
    host_wdata = 16'h0000; bit_mask = 16'h00FF;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b1;
    check("R8 first done", {15'd0, write_done}, 16'd1);
    @(negedge clk);
    host_rd = 1'b0;
    check("R8 second done", {15'd0, write_done}, 16'd1);
    @(negedge clk);
    check("R8 done single", {15'd0, write_done}, 16'd0);
    check("R8 forwarded word", read_data, 16'h00FF);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule